// File: doc/BRIEF.md
# Sixteen-pin GPIO port with configuration lock

This block is the register file and pin control for one 16-pin general-purpose I/O port. A simple 32-bit word-addressed register bus writes each pin's mode and drive speed, the output latch, atomic set and clear masks and an extra top-speed enable. The same bus reads back the configuration, the latch and a synchronised copy of the pin inputs. From this state the block drives, for every pin, the output value, the output enable, the open-drain control, the pull requests and a top-speed select.

A key sequence on one register freezes the configuration of a chosen set of pins until the next reset. It takes three writes with a fixed key pattern and the same pin mask, then two reads. While frozen, the mode fields and top-speed bits of those pins ignore writes. The output latch stays fully writable. In pull-input mode the latch bit of a pin selects its pull direction, so no separate pull register exists.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset both configuration words (word 0 for pins 0-7, word 1 for pins 8-15) read 0x44444444, so every pin is a floating input. The latch (word 3), top-speed word (word 7) and lock word (word 6) read 0, and `lockActive` is 0.
- R2: Pin n owns the 4-bit field at bits 4*(n mod 8) of word 0 or word 1. Field bits 1:0 are the speed, where 00 means input. For an input, bits 3:2 = 00 means analog, 01 floating and 10 pull. For an output, bit 2 selects open drain and bit 3 selects the alternate source. `padOutEn[n]` is high for a nonzero speed, and `padOpenDrain[n]` is high for an output with bit 2 set.
- R3: `padOut[n]` equals `afData[n]` when pin n is an output with bit 3 set. In every other case it equals latch bit n.
- R4: Writing word 4 sets every latch bit whose data bit is 1. Writing word 5 clears every latch bit whose data bit is 1. Zero bits leave the latch unchanged, and both words read 0.
- R5: Word 3 writes and reads the whole 16-bit latch. Word 2 reads `padIn` after a two-flop synchroniser.
- R6: A pin in pull-input mode raises `padPullUp` when its latch bit is 1 and `padPullDown` when it is 0. No other mode requests a pull.
- R7: `padMaxSpeed[n]` is high only when pin n's speed bits are 11 and bit n of word 7 is set.
- R8: Word 6 carries a pin mask in bits 15:0 and a key in bit 16. The lock applies after these accesses to word 6: a write with key 1, a write with key 0, a write with key 1 (same mask each time), then two reads. The first read returns key 0 and the second returns key 1, and `lockActive` rises with the second read.
- R9: While locked, writes to the configuration fields and word 7 bits of masked pins are ignored, and unmasked pins still update. The latch and the set and clear words stay writable.
- R10: A word 6 write with the wrong key, or with a mask that differs from the previous one, returns the sequence to its start and applies no lock.
- R11: Once the lock is active, word 6 writes are ignored and the mask and key stay frozen until reset.
- R12: `rdData` is registered. It shows the word addressed during a read-enable cycle from the following cycle onward and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Word index of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| padIn | input | 16 | Pin input levels |
| afData | input | 16 | Alternate-function output values |
| padOut | output | 16 | Per-pin output value |
| padOutEn | output | 16 | Per-pin output driver enable |
| padOpenDrain | output | 16 | Per-pin open-drain select |
| padPullUp | output | 16 | Per-pin pull-up request |
| padPullDown | output | 16 | Per-pin pull-down request |
| padMaxSpeed | output | 16 | Per-pin top drive speed select |
| lockActive | output | 1 | Configuration lock is in force |

## Verification
A corrupted configuration field shows on the pad controls of its pin in the cycle after the write. A wrong latch shows on `padOut` or the pull requests in the same way. A lock state machine in the wrong state gives itself away on the next word 6 read, because the key bit in that read comes back wrong. It also shows when `lockActive` rises early, late or never. Faulty freezing appears at the first configuration write after locking, which reads back with the masked fields either changed or wrongly kept. Broken sequences, abandoned with a changed mask or a wrong key, are followed by a write that must still take effect.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int PINS    = 16;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NIB_W   = 4;
  localparam int HALF    = PINS / 2;
  localparam int KEY_BIT = PINS;
  localparam logic [NIB_W-1:0] RESET_NIB = 4'b0100;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG_LO = 3'd0,
    REG_CFG_HI = 3'd1,
    REG_INPUT  = 3'd2,
    REG_LATCH  = 3'd3,
    REG_SET    = 3'd4,
    REG_CLR    = 3'd5,
    REG_LOCK   = 3'd6,
    REG_FAST   = 3'd7
  } regSel_t;

  // strobes and lock view handed from control to datapath
  typedef struct packed {
    logic            cfgLo;
    logic            cfgHi;
    logic            latch;
    logic            setBits;
    logic            clrBits;
    logic            fast;
    logic [PINS-1:0] frozen;
    logic            lockRdKey;
    logic [PINS-1:0] lockMask;
  } strobe_t;
endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [KEY_BIT:0]  wrKeyMask,
  output strobe_t           strb,
  output logic              lockActive
);
  typedef enum logic [2:0] {
    LK_IDLE, LK_ARM1, LK_ARM2, LK_ARM3, LK_READ1, LK_HELD
  } lockState_t;

  lockState_t state, stateNext;
  logic [PINS-1:0] maskQ;
  logic lockWr, lockRd, keyIn, sameMask;

  assign lockWr   = wrEn && (regAddr == REG_LOCK);
  assign lockRd   = rdEn && !wrEn && (regAddr == REG_LOCK);
  assign keyIn    = wrKeyMask[KEY_BIT];
  assign sameMask = (wrKeyMask[PINS-1:0] == maskQ);

  always_comb begin
    stateNext = state;
    unique case (state)
      LK_IDLE:  if (lockWr && keyIn) stateNext = LK_ARM1;
      LK_ARM1:  if (lockWr) stateNext = (!keyIn && sameMask) ? LK_ARM2 : LK_IDLE;
      LK_ARM2:  if (lockWr) stateNext = (keyIn && sameMask) ? LK_ARM3 : LK_IDLE;
      LK_ARM3:  if (lockWr) stateNext = LK_IDLE;
                else if (lockRd) stateNext = LK_READ1;
      LK_READ1: if (lockWr) stateNext = LK_IDLE;
                else if (lockRd) stateNext = LK_HELD;
      LK_HELD:  stateNext = LK_HELD;
      default:  stateNext = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= LK_IDLE;
      maskQ <= '0;
    end else begin
      state <= stateNext;
      if (lockWr && state != LK_HELD) maskQ <= wrKeyMask[PINS-1:0];
    end
  end

  assign lockActive     = (state == LK_HELD);
  assign strb.cfgLo     = wrEn && (regAddr == REG_CFG_LO);
  assign strb.cfgHi     = wrEn && (regAddr == REG_CFG_HI);
  assign strb.latch     = wrEn && (regAddr == REG_LATCH);
  assign strb.setBits   = wrEn && (regAddr == REG_SET);
  assign strb.clrBits   = wrEn && (regAddr == REG_CLR);
  assign strb.fast      = wrEn && (regAddr == REG_FAST);
  assign strb.frozen    = lockActive ? maskQ : '0;
  assign strb.lockRdKey = (state == LK_READ1) || lockActive;
  assign strb.lockMask  = maskQ;

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> lockActive);
  assert_mask_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> $stable(strb.lockMask));
  assert_lock_needs_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockActive) |-> $past(lockRd));
endmodule

// File: rtl/gpio_lock_dp.sv
module gpio_lock_dp
  import gpio_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   afData,
  output logic [DATA_W-1:0] rdData,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOutEn,
  output logic [PINS-1:0]   padOpenDrain,
  output logic [PINS-1:0]   padPullUp,
  output logic [PINS-1:0]   padPullDown,
  output logic [PINS-1:0]   padMaxSpeed
);
  logic [NIB_W-1:0]  cfgNib [PINS];
  logic [PINS-1:0]   latchQ, fastQ, syncA, syncB;
  logic [DATA_W-1:0] cfgLoWord, cfgHiWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PINS; i++) cfgNib[i] <= RESET_NIB;
    end else begin
      for (int i = 0; i < PINS; i++)
        if (!strb.frozen[i] && ((i < HALF) ? strb.cfgLo : strb.cfgHi))
          cfgNib[i] <= wrData[(i % HALF)*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      fastQ  <= '0;
      syncA  <= '0;
      syncB  <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (strb.fast) fastQ <= (fastQ & strb.frozen) | (wrData[PINS-1:0] & ~strb.frozen);
      if (strb.latch)        latchQ <= wrData[PINS-1:0];
      else if (strb.setBits) latchQ <= latchQ | wrData[PINS-1:0];
      else if (strb.clrBits) latchQ <= latchQ & ~wrData[PINS-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < HALF; i++) begin
      cfgLoWord[i*NIB_W +: NIB_W] = cfgNib[i];
      cfgHiWord[i*NIB_W +: NIB_W] = cfgNib[i + HALF];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      case (regAddr)
        REG_CFG_LO: rdData <= cfgLoWord;
        REG_CFG_HI: rdData <= cfgHiWord;
        REG_INPUT:  rdData <= {{(DATA_W-PINS){1'b0}}, syncB};
        REG_LATCH:  rdData <= {{(DATA_W-PINS){1'b0}}, latchQ};
        REG_LOCK:   rdData <= {{(DATA_W-PINS-1){1'b0}}, strb.lockRdKey, strb.lockMask};
        REG_FAST:   rdData <= {{(DATA_W-PINS){1'b0}}, fastQ};
        default:    rdData <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [1:0] spd, sub;
    logic isOut;
    assign spd   = cfgNib[g][1:0];
    assign sub   = cfgNib[g][3:2];
    assign isOut = (spd != 2'b00);
    assign padOutEn[g]     = isOut;
    assign padOpenDrain[g] = isOut && sub[0];
    assign padOut[g]       = (isOut && sub[1]) ? afData[g] : latchQ[g];
    assign padPullUp[g]    = !isOut && (sub == 2'b10) && latchQ[g];
    assign padPullDown[g]  = !isOut && (sub == 2'b10) && !latchQ[g];
    assign padMaxSpeed[g]  = (spd == 2'b11) && fastQ[g];

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
      strb.frozen[g] |=> $stable(cfgNib[g]));
  end

  assert_set_effect_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBits && !strb.latch |=>
      ((latchQ & $past(wrData[PINS-1:0])) == $past(wrData[PINS-1:0])));
  assert_clr_effect_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrBits && !strb.latch |=> ((latchQ & $past(wrData[PINS-1:0])) == '0));
  assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullUp & padPullDown) == '0) && (((padPullUp | padPullDown) & padOutEn) == '0));
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   afData,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOutEn,
  output logic [PINS-1:0]   padOpenDrain,
  output logic [PINS-1:0]   padPullUp,
  output logic [PINS-1:0]   padPullDown,
  output logic [PINS-1:0]   padMaxSpeed,
  output logic              lockActive
);
  strobe_t strb;

  gpio_lock_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrKeyMask(wrData[KEY_BIT:0]), .strb(strb), .lockActive(lockActive)
  );

  gpio_lock_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .padIn(padIn), .afData(afData), .rdData(rdData),
    .padOut(padOut), .padOutEn(padOutEn), .padOpenDrain(padOpenDrain),
    .padPullUp(padPullUp), .padPullDown(padPullDown), .padMaxSpeed(padMaxSpeed)
  );
endmodule

// File: tb/gpio_lock_port_tb_top.sv
module gpio_lock_port_tb_top;
  import gpio_lock_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrEn, rdEn;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] wrData, rdData;
  logic [PINS-1:0] padIn, afData, padOut, padOutEn, padOpenDrain;
  logic [PINS-1:0] padPullUp, padPullDown, padMaxSpeed;
  logic lockActive;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [DATA_W-1:0] exp; string tag; } expItem_t;
  expItem_t expQ[$];

  gpio_lock_port dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .afData(afData),
    .padOut(padOut), .padOutEn(padOutEn), .padOpenDrain(padOpenDrain),
    .padPullUp(padPullUp), .padPullDown(padPullDown), .padMaxSpeed(padMaxSpeed),
    .lockActive(lockActive)
  );

  task automatic checkVal(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp, string tag);
    expItem_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    rdEn = 1'b1; regAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: compares each read result one cycle after the read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() == 0) checkVal("R12 unexpected read", rdData, '0);
        else begin
          expItem_t it;
          it = expQ.pop_front();
          checkVal(it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic finishRun();
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) checkVal("R12 reads left pending", DATA_W'(expQ.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; regAddr = '0; wrData = '0;
    padIn = '0; afData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkVal("R1 padOutEn", 32'(padOutEn), 0);
    checkVal("R1 lockActive", 32'(lockActive), 0);
    busRead(REG_CFG_LO, 32'h44444444, "R1 cfg low");
    busRead(REG_CFG_HI, 32'h44444444, "R1 cfg high");
    busRead(REG_LATCH, 0, "R1 latch");
    busRead(REG_FAST, 0, "R1 fast");
    busRead(REG_LOCK, 0, "R1 lock word");

    // R2 modes: pin0 GP PP, pin1 GP OD, pin2 pull in, pin3 AF PP, pin4 analog
    busWrite(REG_CFG_LO, 32'h4440B852);
    busRead(REG_CFG_LO, 32'h4440B852, "R2 cfg readback");
    checkVal("R2 padOutEn", 32'(padOutEn), 32'h000B);
    checkVal("R2 padOpenDrain", 32'(padOpenDrain), 32'h0002);
    checkVal("R6 pull down", 32'(padPullDown), 32'h0004);
    checkVal("R6 no pull up", 32'(padPullUp), 0);

    // R3 output value source
    busWrite(REG_LATCH, 32'h0001);
    checkVal("R3 latch drives GP pin", 32'(padOut & 16'h000F), 32'h1);
    @(negedge clk); afData = 16'h0008; #1;
    checkVal("R3 AF pin follows afData", 32'(padOut & 16'h000F), 32'h9);

    // R4 set/clear
    busWrite(REG_SET, 32'h0004);
    checkVal("R6 pull up", 32'(padPullUp), 32'h0004);
    checkVal("R6 pull down off", 32'(padPullDown), 0);
    busRead(REG_LATCH, 32'h0005, "R4 set");
    busWrite(REG_SET, 32'h0000);
    busWrite(REG_CLR, 32'h0000);
    busRead(REG_LATCH, 32'h0005, "R4 zeros ignored");
    busWrite(REG_CLR, 32'h0001);
    busRead(REG_LATCH, 32'h0004, "R4 clear");
    checkVal("R3 padOut after clear", 32'(padOut & 16'h000F), 32'hC);
    busRead(REG_SET, 0, "R4 set word reads zero");

    // R5 input synchroniser
    @(negedge clk); padIn = 16'hA5C3;
    repeat (3) @(negedge clk);
    busRead(REG_INPUT, 32'h0000A5C3, "R5 input status");

    // R7 top speed
    busWrite(REG_CFG_HI, 32'h44444433);
    busWrite(REG_FAST, 32'h0500);
    checkVal("R7 max speed only on 11 pins", 32'(padMaxSpeed), 32'h0100);
    busRead(REG_FAST, 32'h0500, "R7 fast readback");

    // R12 read data held until next read
    busRead(REG_LATCH, 32'h0004, "R5 latch read");
    busWrite(REG_LATCH, 32'h00FF);
    checkVal("R12 rdData held", rdData, 32'h0004);
    busRead(REG_LATCH, 32'h00FF, "R5 latch direct write");

    // R10 broken sequences
    busWrite(REG_LOCK, 32'h000100FF);
    busWrite(REG_LOCK, 32'h000000F0);   // mask changed
    busWrite(REG_LOCK, 32'h000100F0);
    busWrite(REG_LOCK, 32'h000100F0);   // wrong key
    busRead(REG_LOCK, 32'h000000F0, "R10 key stays 0");
    busRead(REG_LOCK, 32'h000000F0, "R10 key stays 0 again");
    checkVal("R10 no lock after bad key", 32'(lockActive), 0);
    busWrite(REG_LOCK, 32'h00010101);
    busWrite(REG_LOCK, 32'h00000101);
    busWrite(REG_LOCK, 32'h00010111);   // mask changed on third write
    busRead(REG_LOCK, 32'h00000111, "R10 read after bad mask");
    busRead(REG_LOCK, 32'h00000111, "R10 second read after bad mask");
    checkVal("R10 no lock after bad mask", 32'(lockActive), 0);
    busWrite(REG_CFG_LO, 32'h4440B853);
    busRead(REG_CFG_LO, 32'h4440B853, "R10 config still writable");

    // R8 full sequence on pins 0 and 8
    busWrite(REG_LOCK, 32'h00010101);
    busWrite(REG_LOCK, 32'h00000101);
    busWrite(REG_LOCK, 32'h00010101);
    checkVal("R8 not locked before reads", 32'(lockActive), 0);
    busRead(REG_LOCK, 32'h00000101, "R8 first read key 0");
    busRead(REG_LOCK, 32'h00010101, "R8 second read key 1");
    checkVal("R8 lockActive", 32'(lockActive), 1);

    // R9 frozen fields
    busWrite(REG_CFG_LO, 32'h00000000);
    busRead(REG_CFG_LO, 32'h00000003, "R9 pin0 frozen");
    busWrite(REG_CFG_HI, 32'h00000000);
    busRead(REG_CFG_HI, 32'h00000003, "R9 pin8 frozen");
    busWrite(REG_FAST, 32'h0000);
    busRead(REG_FAST, 32'h0100, "R9 fast bit frozen");
    checkVal("R9 max speed kept", 32'(padMaxSpeed), 32'h0100);
    busWrite(REG_LATCH, 32'h1234);
    busWrite(REG_SET, 32'h8000);
    busRead(REG_LATCH, 32'h9234, "R9 latch writable");

    // R11 lock frozen
    busWrite(REG_LOCK, 32'h0000FFFF);
    busWrite(REG_LOCK, 32'h00010000);
    busRead(REG_LOCK, 32'h00010101, "R11 lock word frozen");
    checkVal("R11 still locked", 32'(lockActive), 1);

    // R1 reset releases lock
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    checkVal("R1 lock cleared by reset", 32'(lockActive), 0);
    busRead(REG_CFG_LO, 32'h44444444, "R1 cfg after reset");
    busRead(REG_LATCH, 0, "R1 latch after reset");

    finishRun();
  end
endmodule